// File: doc/BRIEF.md
# Status Register Group with Edge-Qualified Event Latching

This block gathers a vector of live status conditions from an instrument and turns selected changes on them into sticky event flags. Each condition bit has two filter bits: one arms that bit to record 0-to-1 changes, the other arms it to record 1-to-0 changes. Arming both records any change. Arming neither means that bit never records anything. Recorded events stay set until software reads the event register, which clears it, or until a clear-status pulse arrives.

A mask register selects which event bits contribute to a single registered summary flag. A higher-level status register consumes this flag. A small register port with a 3-bit address, a read strobe and a write strobe gives access to the live condition value, both filter masks, the event flags and the summary mask. Read data appears one cycle after the read strobe.

Top module: `stat_group`

## Requirements
- R1: A read of address 0 returns the value of `cond_in` seen at the read edge, with no latching. A write to address 0 has no effect.
- R2: If a bit's rise-filter bit (address 1) is set, a 0-to-1 change of that `cond_in` bit, taken against the value registered on the previous edge, sets the matching event bit (address 3).
- R3: If a bit's fall-filter bit (address 2) is set, a 1-to-0 change of that `cond_in` bit sets the matching event bit.
- R4: If both filter bits of a bit are set, a change in either direction sets its event bit. If neither is set, that event bit never becomes set.
- R5: Event bits are sticky. Further qualifying changes on a bit that is already set leave it set and are not counted. A read of address 3 returns the flags held before the read and clears them.
- R6: A one-cycle pulse on `clr_stat` clears every event bit.
- R7: The rise filter (address 1), the fall filter (address 2) and the summary mask (address 4) are read-write. Reads and `clr_stat` leave them unchanged.
- R8: A qualifying change in the same cycle as an event read or a `clr_stat` pulse leaves its event bit set after the clear.
- R9: `summary` is registered. It equals the OR over all bits of (event AND mask) as held on the previous edge.
- R10: After reset, the event flags, both filters, the mask, the previous-condition copy and `summary` are all zero.
- R11: `rdata` changes only on the edge after a read strobe. Addresses 5 to 7 read as zero. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_in | input | W | Live condition inputs |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | W | Write data |
| clr_stat | input | 1 | Clear-status pulse |
| rdata | output | W | Read data, valid one cycle after `rd_en` |
| summary | output | 1 | Registered summary flag |

## Verification
The in-module assertions check the following on every cycle:
- event bits never drop outside a clear,
- a qualified edge always leaves its event bit set,
- no event bit appears without a filter bit behind it,
- the filters and the mask hold except when written,
- the summary tracks the masked event flags from the previous cycle,
- a read returns the mask one cycle later.

Only the bench's scenarios can show the value-level behaviour, by reading the registers back:
- rise and fall edges are told apart per bit,
- repeated events are not counted,
- a destructive read returns the pre-clear value,
- an event that coincides with a clear survives it,
- writes to read-only addresses are ignored.

// File: rtl/stat_group.sv
module stat_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_in,
  input  logic [2:0]   addr,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         clr_stat,
  output logic [W-1:0] rdata,
  output logic         summary
);

  localparam logic [2:0] A_COND = 3'd0;
  localparam logic [2:0] A_RISE = 3'd1;
  localparam logic [2:0] A_FALL = 3'd2;
  localparam logic [2:0] A_EVT  = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;

  logic [W-1:0] cond_q, rise_q, fall_q, evt_q, mask_q, hits, rd_mux;
  logic         clr_now;

  assign hits    = (cond_in & ~cond_q & rise_q) | (~cond_in & cond_q & fall_q);
  assign clr_now = clr_stat | (rd_en && addr == A_EVT);

  always_comb begin
    case (addr)
      A_COND:  rd_mux = cond_in;
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_EVT:   rd_mux = evt_q;
      A_MASK:  rd_mux = mask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      evt_q   <= '0;
      mask_q  <= '0;
      rdata   <= '0;
      summary <= 1'b0;
    end else begin
      cond_q  <= cond_in;
      evt_q   <= (clr_now ? '0 : evt_q) | hits;
      summary <= |(evt_q & mask_q);
      if (rd_en) rdata <= rd_mux;
      if (wr_en && addr == A_RISE) rise_q <= wdata;
      if (wr_en && addr == A_FALL) fall_q <= wdata;
      if (wr_en && addr == A_MASK) mask_q <= wdata;
    end
  end

  // R5
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((evt_q & $past(hits)) == $past(hits)));

  // R4
  unfiltered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~($past(rise_q) | $past(fall_q))) == '0));

  // R7
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_RISE) |=> $stable(rise_q));

  // R7
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_FALL) |=> $stable(fall_q));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_MASK) |=> $stable(mask_q));

  // R9
  summary_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary == |($past(evt_q) & $past(mask_q))));

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MASK) |=> (rdata == $past(mask_q)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/sim_stat_group.sv
module sim_stat_group;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cond_in = '0;
  logic [2:0]   addr = '0;
  logic         rd_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         clr_stat = 1'b0;
  logic [W-1:0] rdata;
  logic         summary;

  int errors = 0;
  int checks = 0;
  logic rd_seen = 1'b0;
  logic finished = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  stat_group #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .clr_stat(clr_stat),
    .rdata(rdata), .summary(summary)
  );

  always #10 clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setc(input logic [W-1:0] v);
    cond_in = v;
    @(negedge clk);
  endtask

  task automatic chk_sum(input logic exp, input string tag);
    checks++;
    if (summary !== exp) begin
      errors++;
      $display("FAIL %s: summary=%b expected=%b", tag, summary, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk_sum(1'b0, "R10");
    rd(3'd1, 16'h0000, "R10");
    rd(3'd2, 16'h0000, "R10");
    rd(3'd3, 16'h0000, "R10");
    rd(3'd4, 16'h0000, "R10");
    // R7 read-write
    wr(3'd1, 16'h00FF);
    wr(3'd2, 16'hFF10);
    wr(3'd4, 16'h0001);
    rd(3'd1, 16'h00FF, "R7");
    rd(3'd2, 16'hFF10, "R7");
    rd(3'd4, 16'h0001, "R7");
    // R1 live condition, writes ignored
    setc(16'h0000);
    cond_in = 16'hA5C0;
    rd(3'd0, 16'hA5C0, "R1");
    wr(3'd0, 16'h1234);
    rd(3'd0, 16'hA5C0, "R1");
    // A5C0 rise with rise filter 00FF: bits 6,7 (0xC0); clear by reading
    rd(3'd3, 16'h00C0, "R2");
    setc(16'h0000);  // fall bits 15,13,10,8 with fall filter FF10 -> A500
    rd(3'd3, 16'hA500, "R3");
    rd(3'd3, 16'h0000, "R5");
    // R2 rise bits 0,1
    setc(16'h0003);
    @(negedge clk);
    chk_sum(1'b1, "R9");
    rd(3'd3, 16'h0003, "R2");
    rd(3'd3, 16'h0000, "R5");
    @(negedge clk);
    chk_sum(1'b0, "R9");
    // R3 bit 8: rise ignored (no rise filter), fall recorded
    setc(16'h0103);
    rd(3'd3, 16'h0000, "R3");
    setc(16'h0003);
    rd(3'd3, 16'h0100, "R3");
    // R4 bit 4 both filters: set rise bit4 (00FF already), fall has bit4 (FF10)
    setc(16'h0013);
    rd(3'd3, 16'h0010, "R4");
    setc(16'h0003);
    rd(3'd3, 16'h0010, "R4");
    // R4 neither: clear bit 12 from fall filter, toggle it
    wr(3'd2, 16'hEF10);
    setc(16'h1003);
    setc(16'h0003);
    rd(3'd3, 16'h0000, "R4");
    // R5 no counting
    setc(16'h0002);
    setc(16'h0003);
    setc(16'h0002);
    setc(16'h0003);
    rd(3'd3, 16'h0001, "R5");
    rd(3'd3, 16'h0000, "R5");
    // R6 clear-status; R7 immunity
    setc(16'h0002);
    setc(16'h0003);
    clr_stat = 1'b1;
    @(negedge clk);
    clr_stat = 1'b0;
    rd(3'd3, 16'h0000, "R6");
    rd(3'd1, 16'h00FF, "R7");
    rd(3'd2, 16'hEF10, "R7");
    rd(3'd4, 16'h0001, "R7");
    // R8 edge coincides with event read
    setc(16'h0002);
    cond_in = 16'h0003;
    rd(3'd3, 16'h0000, "R8");
    rd(3'd3, 16'h0001, "R8");
    // R8 edge coincides with clr_stat
    setc(16'h0002);
    cond_in = 16'h0003;
    clr_stat = 1'b1;
    @(negedge clk);
    clr_stat = 1'b0;
    rd(3'd3, 16'h0001, "R8");
    // R11 write to event ignored, unmapped reads zero
    setc(16'h0002);
    setc(16'h0003);
    wr(3'd3, 16'h0000);
    rd(3'd3, 16'h0001, "R11");
    rd(3'd5, 16'h0000, "R11");
    rd(3'd7, 16'h0000, "R11");
    // R9 summary follows mask with one cycle lag
    setc(16'h0002);
    setc(16'h0003);
    @(negedge clk);
    chk_sum(1'b1, "R9");
    wr(3'd4, 16'h0002);
    chk_sum(1'b1, "R9");
    @(negedge clk);
    chk_sum(1'b0, "R9");
    rd(3'd3, 16'h0001, "R9");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule